// File: doc/BRIEF.md
# Block Shared-Exponent 4-bit Quantizer

This block is a streaming packer for signed fixed-point samples. It collects samples into blocks of a fixed, parameterised length. Once a block is complete, it finds the magnitude that needs the most bits and turns that into one power-of-two exponent for the whole block. Every element is then reduced to a signed 4-bit code relative to that exponent. The result leaves the block as a byte stream: first one signed exponent byte, then the packed codes, with two codes in each byte.

An input sample's real value is its raw two's complement integer divided by 2^FRAC_W. The upstream side may end a block early by raising `in_last`. The block then treats the missing positions as zeros and still emits a full-length block. The input side and the output side never run at the same time. While a block is being emitted, the input is held off.

Top module: `bsq_top`

## Requirements
- R1: The block length BLK_LEN is an even parameter from 16 to 256 (default 64). After BLK_LEN samples have been accepted, `in_ready` falls and the block is emitted.
- R2: The exponent byte holds the signed 8-bit integer e, chosen as the smallest e for which the peak magnitude m (real value) satisfies 2^(e-1) <= m < 2^e. The value is clamped to the range -128..127.
- R3: A block whose elements are all zero emits exponent 0, and all of its codes are 0.
- R4: Each code equals x*7/2^e, rounded to the nearest integer with ties going to the even integer, then clamped to -8..+7.
- R5: Each code is a 4-bit two's complement nibble. Element 2j goes into bits [3:0] of code byte j, and element 2j+1 goes into bits [7:4].
- R6: Each block leaves the block in this order: one byte with `out_is_exp`=1, then exactly BLK_LEN/2 code bytes with `out_is_exp`=0. `out_last` is set only on the final code byte.
- R7: If `in_last` arrives with sample n < BLK_LEN, the block is emitted at once. Positions n..BLK_LEN-1 are quantized as zero, and those positions do not affect the exponent.
- R8: `in_ready` is low for as long as `out_valid` is high.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_is_exp` and `out_last` hold their values on the next cycle.
- R10: After reset, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | DATA_W | Signed fixed-point sample, FRAC_W fraction bits |
| in_last | input | 1 | This sample closes the current block |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Exponent byte or two packed codes |
| out_is_exp | output | 1 | Current byte is the exponent |
| out_last | output | 1 | Current byte is the last code byte of the block |

## Verification
The checkers assume that the downstream side follows the valid/ready rule. They also assume that `in_last` is only ever seen together with an accepted sample, so every block reaches the output with a complete byte count. The bench drives `in_valid` and `in_last` only during input phases and clears them before collecting output. It toggles `out_ready` only as a consumer would, so every stall it creates is one the hold and ordering checks are meant to see.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    // Top-level sequencing of a block: gather samples, send exponent, send codes
    typedef enum logic [1:0] {
        ST_FILL      = 2'd0,
        ST_EMIT_EXP  = 2'd1,
        ST_EMIT_CODE = 2'd2
    } bsq_state_e;

    // Constant multiplier applied before the power-of-two division
    localparam int CODE_SCALE = 7;
    localparam int CODE_MAX   = 7;
    localparam int CODE_MIN   = -8;

endpackage

// File: rtl/bsq_exp_calc.sv
// Turns the OR of all block magnitudes into the shift amount and exponent byte.
// The bit length of the OR equals the bit length of the peak magnitude.
module bsq_exp_calc #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 8,
    parameter int KW     = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] mag_or,
    output logic [KW-1:0]     shift_k,
    output logic [7:0]        exp_byte
);

    int ev;

    always_comb begin
        shift_k = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (mag_or[i]) shift_k = KW'(i + 1);
        end
        if (shift_k == '0) begin
            ev = 0;
        end else begin
            ev = int'(shift_k) - FRAC_W;
        end
        if (ev > 127)  ev = 127;
        if (ev < -128) ev = -128;
        exp_byte = ev[7:0];
    end

endmodule

// File: rtl/bsq_code_unit.sv
// Scales one sample by 7 / 2^k, rounds half-to-even, saturates to a nibble.
module bsq_code_unit #(
    parameter int DATA_W = 16,
    parameter int KW     = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [KW-1:0]     shift_k,
    output logic [3:0]        code
);

    import bsq_pkg::*;

    localparam int PW = DATA_W + 4;
    localparam logic signed [PW-1:0] MAXC = PW'(CODE_MAX);
    localparam logic signed [PW-1:0] MINC = PW'(CODE_MIN);

    logic signed [PW-1:0] ext;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] quot;
    logic signed [PW-1:0] rnd;
    logic        [PW-1:0] mask;
    logic        [PW-1:0] rem;
    logic        [PW-1:0] half;
    logic                 up;

    always_comb begin
        ext  = {{4{sample[DATA_W-1]}}, sample};
        prod = (ext <<< 3) - ext;
        quot = prod >>> shift_k;
        mask = ~({PW{1'b1}} << shift_k);
        rem  = prod & mask;
        half = (shift_k == '0) ? '0 : (PW'(1) << (shift_k - KW'(1)));
        up   = (shift_k != '0) && ((rem > half) || ((rem == half) && quot[0]));
        rnd  = quot + PW'(up);
        if (shift_k == '0) begin
            rnd = '0;
        end else if (rnd > MAXC) begin
            rnd = MAXC;
        end else if (rnd < MINC) begin
            rnd = MINC;
        end
        code = rnd[3:0];
    end

endmodule

// File: rtl/bsq_top.sv
module bsq_top #(
    parameter int DATA_W  = 16,
    parameter int FRAC_W  = 8,
    parameter int BLK_LEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_is_exp,
    output logic              out_last
);

    import bsq_pkg::*;

    localparam int IDX_W  = $clog2(BLK_LEN);
    localparam int CNT_W  = IDX_W + 1;
    localparam int PAIRS  = BLK_LEN / 2;
    localparam int PAIR_W = IDX_W - 1;
    localparam int KW     = $clog2(DATA_W + 1);
    localparam int LANES  = 2;

    if (BLK_LEN < 16 || BLK_LEN > 256 || (BLK_LEN % 2) != 0) begin : g_bad_len
        $error("BLK_LEN must be even and within 16..256");
    end

    typedef struct packed {
        bsq_state_e        state;
        logic [CNT_W-1:0]  wr_cnt;
        logic [CNT_W-1:0]  fill_cnt;
        logic [PAIR_W-1:0] rd_pair;
        logic [DATA_W-1:0] mag_or;
    } bsq_regs_t;

    bsq_regs_t r_d, r_q;

    logic [DATA_W-1:0] blk_mem_q [BLK_LEN];
    logic [DATA_W-1:0] in_mag;
    logic              in_acc;
    logic              out_acc;
    logic [KW-1:0]     shift_k;
    logic [7:0]        exp_byte;
    logic [3:0]        lane_code [LANES];

    assign in_ready = (r_q.state == ST_FILL);
    assign in_acc   = in_valid && in_ready;
    assign out_acc  = out_valid && out_ready;
    assign in_mag   = in_data[DATA_W-1] ? (~in_data + DATA_W'(1)) : in_data;

    bsq_exp_calc #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .KW     (KW)
    ) u_exp (
        .mag_or   (r_q.mag_or),
        .shift_k  (shift_k),
        .exp_byte (exp_byte)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IDX_W-1:0]  elem_idx;
        logic [DATA_W-1:0] elem_val;
        assign elem_idx = {r_q.rd_pair, 1'(g)};
        assign elem_val = (CNT_W'(elem_idx) < r_q.fill_cnt) ? blk_mem_q[elem_idx] : '0;
        bsq_code_unit #(
            .DATA_W (DATA_W),
            .KW     (KW)
        ) u_code (
            .sample  (elem_val),
            .shift_k (shift_k),
            .code    (lane_code[g])
        );
    end

    always_comb begin
        out_valid  = 1'b0;
        out_is_exp = 1'b0;
        out_last   = 1'b0;
        out_data   = '0;
        case (r_q.state)
            ST_EMIT_EXP: begin
                out_valid  = 1'b1;
                out_is_exp = 1'b1;
                out_data   = exp_byte;
            end
            ST_EMIT_CODE: begin
                out_valid = 1'b1;
                out_data  = {lane_code[1], lane_code[0]};
                out_last  = (r_q.rd_pair == PAIR_W'(PAIRS - 1));
            end
            default: ;
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_FILL: begin
                if (in_acc) begin
                    r_d.mag_or = r_q.mag_or | in_mag;
                    r_d.wr_cnt = r_q.wr_cnt + CNT_W'(1);
                    if (in_last || (r_q.wr_cnt == CNT_W'(BLK_LEN - 1))) begin
                        r_d.state    = ST_EMIT_EXP;
                        r_d.fill_cnt = r_q.wr_cnt + CNT_W'(1);
                        r_d.rd_pair  = '0;
                    end
                end
            end
            ST_EMIT_EXP: begin
                if (out_acc) r_d.state = ST_EMIT_CODE;
            end
            ST_EMIT_CODE: begin
                if (out_acc) begin
                    r_d.rd_pair = r_q.rd_pair + PAIR_W'(1);
                    if (out_last) begin
                        r_d.state   = ST_FILL;
                        r_d.wr_cnt  = '0;
                        r_d.mag_or  = '0;
                        r_d.rd_pair = '0;
                    end
                end
            end
            default: r_d.state = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_FILL;
            r_q.wr_cnt   <= '0;
            r_q.fill_cnt <= '0;
            r_q.rd_pair  <= '0;
            r_q.mag_or   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (in_acc) blk_mem_q[r_q.wr_cnt[IDX_W-1:0]] <= in_data;
    end

endmodule

// File: rtl/bsq_check.sv
module bsq_check #(
    parameter int DATA_W  = 16,
    parameter int FRAC_W  = 8,
    parameter int BLK_LEN = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_is_exp,
    input logic       out_last
);

    localparam int PAIRS  = BLK_LEN / 2;
    localparam int EXP_HI = (DATA_W - FRAC_W > 127) ? 127 : (DATA_W - FRAC_W);
    localparam int EXP_LO = (1 - FRAC_W < -128) ? -128 : (1 - FRAC_W);

    int code_cnt;
    int exp_val;

    assign exp_val = int'($signed(out_data));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_cnt <= 0;
        end else if (out_valid && out_ready) begin
            if (out_is_exp) code_cnt <= 0;
            else            code_cnt <= code_cnt + 1;
        end
    end

    AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                      && $stable(out_is_exp) && $stable(out_last))); // R9

    AST_EXP_THEN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_is_exp) |=> (out_valid && !out_is_exp)); // R6

    AST_LAST_IS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && !out_is_exp)); // R6

    AST_BYTE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (code_cnt == PAIRS - 1)); // R6

    AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_exp) |-> ((exp_val == 0) || (exp_val >= EXP_LO && exp_val <= EXP_HI))); // R2

    AST_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R1

endmodule

bind bsq_top bsq_check #(
    .DATA_W  (DATA_W),
    .FRAC_W  (FRAC_W),
    .BLK_LEN (BLK_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_is_exp (out_is_exp),
    .out_last   (out_last)
);

// File: tb/sim_bsq_top.sv
`timescale 1ns/1ps
module sim_bsq_top;

    localparam int DATA_W  = 16;
    localparam int FRAC_W  = 8;
    localparam int BLK_LEN = 64;
    localparam int PAIRS   = BLK_LEN / 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [DATA_W-1:0] in_data;
    logic              in_last;
    logic              out_valid;
    logic              out_ready;
    logic [7:0]        out_data;
    logic              out_is_exp;
    logic              out_last;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int samp [BLK_LEN];
    int exp_e;
    int exp_bytes [PAIRS];
    logic [7:0] got_bytes [PAIRS+1];
    bit         got_isexp [PAIRS+1];
    bit         got_last  [PAIRS+1];
    int         stall_bad;
    int         hold_bad;

    always #5 clk = ~clk;

    bsq_top #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .BLK_LEN(BLK_LEN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_is_exp(out_is_exp), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int ref_code(input int v, input int k);
        int num, den, a, qa, r, res;
        if (k == 0) return 0;
        num = v * 7;
        den = 1 << k;
        a   = (num < 0) ? -num : num;
        qa  = a / den;
        r   = a % den;
        if ((2 * r > den) || ((2 * r == den) && (qa % 2 == 1))) qa++;
        res = (num < 0) ? -qa : qa;
        if (res > 7)  res = 7;
        if (res < -8) res = -8;
        return res;
    endfunction

    task automatic ref_block(input int n);
        int m, k, v0, v1;
        m = 0;
        for (int i = 0; i < n; i++) begin
            int a = (samp[i] < 0) ? -samp[i] : samp[i];
            if (a > m) m = a;
        end
        k = 0;
        while ((1 << k) <= m) k++;
        exp_e = (m == 0) ? 0 : k - FRAC_W;
        if (exp_e > 127)  exp_e = 127;
        if (exp_e < -128) exp_e = -128;
        for (int j = 0; j < PAIRS; j++) begin
            v0 = (2*j   < n) ? samp[2*j]   : 0;
            v1 = (2*j+1 < n) ? samp[2*j+1] : 0;
            exp_bytes[j] = ((ref_code(v1, k) & 15) << 4) | (ref_code(v0, k) & 15);
        end
    endtask

    task automatic send(input int n, input bit with_last);
        for (int i = 0; i < n; i++) begin
            bit hs;
            hs = 0;
            while (!hs) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = DATA_W'(samp[i]);
                in_last  = with_last && (i == n - 1);
                hs = in_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic collect(input bit stall);
        int got;
        int tick;
        bit pend;
        logic [7:0] pd;
        got = 0; tick = 0; pend = 0; pd = '0;
        stall_bad = 0; hold_bad = 0;
        while (got <= PAIRS) begin
            if (tick > 0) @(negedge clk);
            tick++;
            if (pend) begin
                if (!(out_valid && out_data == pd)) hold_bad++;
                pend = 0;
            end
            out_ready = stall ? (tick % 3 != 1) : 1'b1;
            if (out_valid) begin
                if (in_ready) stall_bad++;
                if (out_ready) begin
                    got_bytes[got] = out_data;
                    got_isexp[got] = out_is_exp;
                    got_last[got]  = out_last;
                    got++;
                end else begin
                    pend = 1;
                    pd   = out_data;
                end
            end
            @(posedge clk);
        end
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    task automatic compare(input string req);
        chk(got_isexp[0] == 1'b1, "R6", {req, " exp flag"}, int'(got_isexp[0]), 1);
        chk($signed(got_bytes[0]) == exp_e, "R2", {req, " exponent"}, int'($signed(got_bytes[0])), exp_e);
        for (int j = 0; j < PAIRS; j++) begin
            chk(int'(got_bytes[j+1]) == exp_bytes[j], req, $sformatf("code byte %0d (R4 R5)", j),
                int'(got_bytes[j+1]), exp_bytes[j]);
        end
        chk(!got_isexp[1] && !got_last[1] && got_last[PAIRS] && !got_isexp[PAIRS], "R6",
            {req, " framing flags"}, int'(got_last[PAIRS]), 1);
        chk(stall_bad == 0, "R8", {req, " in_ready during emission"}, stall_bad, 0);
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R10", "in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_full_mixed();
        for (int i = 0; i < BLK_LEN; i++) samp[i] = ((i * 37) % 211) - 105;
        ref_block(BLK_LEN);
        send(BLK_LEN, 0);
        chk(in_ready == 1'b0, "R1", "in_ready low after full block", int'(in_ready), 0);
        collect(0);
        compare("R4 mixed");
        chk(in_ready == 1'b1, "R1", "in_ready back after block", int'(in_ready), 1);
    endtask

    task automatic t_wide_range();
        for (int i = 0; i < BLK_LEN; i++) samp[i] = ((i * 523) % 30000) - 15000;
        ref_block(BLK_LEN);
        send(BLK_LEN, 1);
        collect(0);
        compare("R2 wide");
    endtask

    task automatic t_zero();
        for (int i = 0; i < BLK_LEN; i++) samp[i] = 0;
        ref_block(BLK_LEN);
        send(BLK_LEN, 0);
        collect(0);
        compare("R3 zero");
        chk(got_bytes[0] == 8'd0, "R3", "zero block exponent", int'(got_bytes[0]), 0);
    endtask

    task automatic t_partial();
        for (int i = 0; i < BLK_LEN; i++) samp[i] = 9999;
        samp[0] = 300; samp[1] = -7; samp[2] = 1200; samp[3] = 0; samp[4] = -1201;
        ref_block(5);
        send(5, 1);
        chk(in_ready == 1'b0, "R7", "early close stops input", int'(in_ready), 0);
        collect(0);
        compare("R7 partial");
        chk(got_bytes[4] == 8'd0, "R7", "zero-filled byte", int'(got_bytes[4]), 0);
    endtask

    task automatic t_ties();
        for (int i = 0; i < BLK_LEN; i++) samp[i] = (i % 7) - 3;
        samp[0] = 8; samp[1] = -8; samp[2] = 6; samp[3] = -6; samp[4] = 5; samp[5] = 2; samp[6] = 1;
        ref_block(BLK_LEN);
        send(BLK_LEN, 0);
        collect(0);
        compare("R4 ties");
        chk(got_bytes[1] == 8'hC4, "R4", "tie 3.5 to 4 and -3.5 to -4", int'(got_bytes[1]), 'hC4);
    endtask

    task automatic t_extreme();
        for (int i = 0; i < BLK_LEN; i++) samp[i] = (i * 97) % 400;
        samp[0] = -32768; samp[1] = 16384;
        ref_block(BLK_LEN);
        send(BLK_LEN, 0);
        collect(0);
        compare("R2 extreme");
        chk(got_bytes[0] == 8'd8, "R2", "largest exponent", int'(got_bytes[0]), 8);
        chk(got_bytes[1] == 8'h2C, "R5", "nibble order", int'(got_bytes[1]), 'h2C);
    endtask

    task automatic t_stall();
        for (int i = 0; i < BLK_LEN; i++) samp[i] = ((i * 13) % 61) - 30;
        ref_block(BLK_LEN);
        send(BLK_LEN, 0);
        collect(1);
        compare("R9 stall");
        chk(hold_bad == 0, "R9", "output held under back-pressure", hold_bad, 0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_mixed();
        t_wide_range();
        t_zero();
        t_partial();
        t_ties();
        t_extreme();
        t_stall();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule